// File: doc/BRIEF.md
# Floating-Point Compare Unit

This block compares two register-format binary floating-point values (sign, biased exponent, fraction) and returns a register-width boolean together with an invalid-operation flag. A 2-bit opcode selects one of four predicates: unordered, equal, less-than and less-or-equal. Ordering comes from comparing the sign, exponent and fraction fields only. The block uses no subtractor and no format conversion.

The result is registered. An operand pair presented with `cmp_valid` high produces `res_valid`, `res_word` and `res_invalid` one clock later. True is encoded as a single set bit just below the sign position. For the default 64-bit format this is 0x4000_0000_0000_0000. False is all zeros. Trap handling is left to the surrounding pipeline.

Top module: `fp_compare_unit`

## Requirements
- R1: Every result word is either all zeros (false) or the value with only bit W-2 set (true, 0x4000_0000_0000_0000 for W=64); no other pattern is ever produced.
- R2: A NaN is a value with an all-ones exponent and a nonzero fraction. When either operand is a NaN, opcode 00 (unordered) returns true, and opcodes 01 (equal), 10 (less-than) and 11 (less-or-equal) return false.
- R3: The quiet bit is the most significant fraction bit (bit 51 for W=64); a NaN with that bit clear is signalling. `res_invalid` is high with the result when either operand is a signalling NaN, for every opcode, and low when only quiet NaNs or ordinary values are present.
- R4: When both operands are zero, of either sign, equal and less-or-equal return true and less-than returns false.
- R5: For non-NaN operands that are not both zero, equal is true exactly when the two bit patterns are identical.
- R6: For non-NaN operands that are not both zero and whose signs differ, a negative A is less than (and less-or-equal to) a positive B, and a positive A is neither less than nor less-or-equal to a negative B.
- R7: With both signs positive, ordering compares the exponent fields first and then the fraction fields, so the value with the smaller magnitude is the lesser.
- R8: With both signs negative, the sense is reversed: the operand with the larger magnitude is the lesser.
- R9: `res_valid` follows `cmp_valid` by exactly one clock, the result belongs to the operands sampled at that edge, and `res_invalid` is high only while `res_valid` is high.
- R10: After reset, `res_valid`, `res_invalid` and `res_word` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmp_valid | input | 1 | Operands and opcode are valid this cycle |
| cmp_op | input | 2 | 00 unordered, 01 equal, 10 less-than, 11 less-or-equal |
| opnd_a | input | W | First operand (A) |
| opnd_b | input | W | Second operand (B) |
| res_valid | output | 1 | Result valid, one clock after `cmp_valid` |
| res_word | output | W | Boolean result word |
| res_invalid | output | 1 | Signalling NaN seen; pulses with `res_valid` |

## Verification
The bench builds the unit with its default field widths: 11 exponent bits and 52 fraction bits. With these widths the true constant is 0x4000_0000_0000_0000 and the quiet bit is bit 51. The standard encodings of ±0, ±1, ±2, 1.5, infinities, the smallest denormal, quiet NaNs and signalling NaNs can then be written directly as stimulus. Each operand pair is run through all four opcodes. This covers mixed signs, equal exponents with different fractions, negative pairs, zero pairs of every sign mix, and NaNs in each operand position.

// File: rtl/fp_compare_unit.sv
module fp_compare_unit #(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52,
  localparam int W     = 1 + EXP_W + FRAC_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cmp_valid,
  input  logic [1:0]   cmp_op,
  input  logic [W-1:0] opnd_a,
  input  logic [W-1:0] opnd_b,
  output logic         res_valid,
  output logic [W-1:0] res_word,
  output logic         res_invalid
);

  localparam logic [W-1:0] TRUE_WORD = {2'b01, {(W-2){1'b0}}};

  logic              sgn_a, sgn_b;
  logic [EXP_W-1:0]  exp_a, exp_b;
  logic [FRAC_W-1:0] frc_a, frc_b;

  assign sgn_a = opnd_a[W-1];
  assign sgn_b = opnd_b[W-1];
  assign exp_a = opnd_a[W-2 -: EXP_W];
  assign exp_b = opnd_b[W-2 -: EXP_W];
  assign frc_a = opnd_a[FRAC_W-1:0];
  assign frc_b = opnd_b[FRAC_W-1:0];

  logic nan_a, nan_b, sig_a, sig_b, any_nan, any_sig, both_zero;

  assign nan_a     = (&exp_a) & (|frc_a);
  assign nan_b     = (&exp_b) & (|frc_b);
  assign sig_a     = nan_a & ~frc_a[FRAC_W-1];
  assign sig_b     = nan_b & ~frc_b[FRAC_W-1];
  assign any_nan   = nan_a | nan_b;
  assign any_sig   = sig_a | sig_b;
  assign both_zero = ~(|opnd_a[W-2:0]) & ~(|opnd_b[W-2:0]);

  logic mag_gt, mag_eq;

  always_comb begin
    if (exp_a != exp_b) mag_gt = exp_a > exp_b;
    else                mag_gt = frc_a > frc_b;
  end
  assign mag_eq = opnd_a[W-2:0] == opnd_b[W-2:0];

  logic is_eq, is_lt, is_le, pick;

  assign is_eq = both_zero | (opnd_a == opnd_b);

  always_comb begin
    if (both_zero)            is_lt = 1'b0;
    else if (sgn_a != sgn_b)  is_lt = sgn_a;
    else if (sgn_a)           is_lt = mag_gt;
    else                      is_lt = ~mag_gt & ~mag_eq;
  end

  always_comb begin
    if (both_zero)            is_le = 1'b1;
    else if (sgn_a != sgn_b)  is_le = sgn_a;
    else if (sgn_a)           is_le = mag_gt | mag_eq;
    else                      is_le = ~mag_gt;
  end

  always_comb begin
    unique case (cmp_op)
      2'b00:   pick = any_nan;
      2'b01:   pick = ~any_nan & is_eq;
      2'b10:   pick = ~any_nan & is_lt;
      default: pick = ~any_nan & is_le;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid   <= 1'b0;
      res_invalid <= 1'b0;
      res_word    <= '0;
    end else begin
      res_valid   <= cmp_valid;
      res_invalid <= cmp_valid & any_sig;
      if (cmp_valid) res_word <= pick ? TRUE_WORD : '0;
    end
  end

endmodule

// File: rtl/fp_compare_unit_chk.sv
module fp_compare_unit_chk #(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52,
  localparam int W     = 1 + EXP_W + FRAC_W
) (
  input logic         clk,
  input logic         rst_n,
  input logic         cmp_valid,
  input logic [1:0]   cmp_op,
  input logic [W-1:0] opnd_a,
  input logic [W-1:0] opnd_b,
  input logic         res_valid,
  input logic [W-1:0] res_word,
  input logic         res_invalid
);

  localparam logic [W-1:0] T_WORD = {2'b01, {(W-2){1'b0}}};

  logic a_nan, b_nan, a_snan, b_snan, zz;
  assign a_nan  = (opnd_a[W-2 -: EXP_W] == '1) && (opnd_a[FRAC_W-1:0] != '0);
  assign b_nan  = (opnd_b[W-2 -: EXP_W] == '1) && (opnd_b[FRAC_W-1:0] != '0);
  assign a_snan = a_nan && !opnd_a[FRAC_W-1];
  assign b_snan = b_nan && !opnd_b[FRAC_W-1];
  assign zz     = (opnd_a[W-2:0] == '0) && (opnd_b[W-2:0] == '0);

  p_word_encoding_r1: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_word == '0 || res_word == T_WORD));

  p_nan_unordered_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_valid && (a_nan || b_nan)) |=> (res_word == (($past(cmp_op) == 2'b00) ? T_WORD : '0)));

  p_snan_invalid_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_valid && (a_snan || b_snan)) |=> res_invalid);

  p_quiet_no_invalid_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_valid && !a_snan && !b_snan) |=> !res_invalid);

  p_zero_pair_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_valid && zz && cmp_op != 2'b00) |=> (res_word == (($past(cmp_op) == 2'b10) ? '0 : T_WORD)));

  p_valid_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_valid |=> res_valid);

  p_valid_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !cmp_valid |=> !res_valid);

  p_invalid_gated_r9: assert property (@(posedge clk) disable iff (!rst_n)
    res_invalid |-> res_valid);

endmodule

bind fp_compare_unit fp_compare_unit_chk #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmp_valid(cmp_valid), .cmp_op(cmp_op),
  .opnd_a(opnd_a), .opnd_b(opnd_b), .res_valid(res_valid),
  .res_word(res_word), .res_invalid(res_invalid)
);

// File: tb/test_fp_compare_unit.sv
module test_fp_compare_unit;
  localparam int W = 64;
  localparam logic [63:0] TW = 64'h4000_0000_0000_0000;

  localparam logic [63:0] P0 = 64'h0, N0 = 64'h8000_0000_0000_0000;
  localparam logic [63:0] P1 = 64'h3FF0_0000_0000_0000, N1 = 64'hBFF0_0000_0000_0000;
  localparam logic [63:0] P2 = 64'h4000_0000_0000_0000, N2 = 64'hC000_0000_0000_0000;
  localparam logic [63:0] P15 = 64'h3FF8_0000_0000_0000, N15 = 64'hBFF8_0000_0000_0000;
  localparam logic [63:0] PINF = 64'h7FF0_0000_0000_0000, NINF = 64'hFFF0_0000_0000_0000;
  localparam logic [63:0] DEN = 64'h0000_0000_0000_0001;
  localparam logic [63:0] QN = 64'h7FF8_0000_0000_0000, SN = 64'h7FF0_0000_0000_0001;

  logic clk = 0, rst_n = 0, cmp_valid = 0;
  logic [1:0] cmp_op = 0;
  logic [63:0] opnd_a = 0, opnd_b = 0;
  logic res_valid, res_invalid;
  logic [63:0] res_word;

  always #10 clk = ~clk;

  fp_compare_unit i_fp_compare_unit (
    .clk(clk), .rst_n(rst_n), .cmp_valid(cmp_valid), .cmp_op(cmp_op),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .res_valid(res_valid),
    .res_word(res_word), .res_invalid(res_invalid)
  );

  typedef struct { logic [63:0] word; logic inv; string req; } item_t;
  item_t sb[$];
  int checks = 0, errors = 0;
  bit done = 0;

  function automatic bit is_nan(logic [63:0] v);
    return v[62:52] == 11'h7FF && v[51:0] != 0;
  endfunction

  function automatic item_t model(logic [1:0] op, logic [63:0] a, logic [63:0] b, string req);
    item_t it;
    bit r, less, eq, zz;
    it.req = req;
    it.inv = (is_nan(a) && !a[51]) || (is_nan(b) && !b[51]);
    zz = (a[62:0] == 0) && (b[62:0] == 0);
    eq = zz || a == b;
    if (zz) less = 0;
    else if (a[63] && !b[63]) less = 1;
    else if (!a[63] && b[63]) less = 0;
    else if (!a[63]) less = (a[62:52] < b[62:52]) || (a[62:52] == b[62:52] && a[51:0] < b[51:0]);
    else less = (a[62:52] > b[62:52]) || (a[62:52] == b[62:52] && a[51:0] > b[51:0]);
    if (is_nan(a) || is_nan(b)) r = (op == 2'b00);
    else case (op)
      2'b00: r = 0;
      2'b01: r = eq;
      2'b10: r = less;
      default: r = less || eq;
    endcase
    it.word = r ? TW : 64'h0;
    return it;
  endfunction

  task automatic drive(logic [1:0] op, logic [63:0] a, logic [63:0] b, string req);
    @(negedge clk);
    cmp_valid = 1; cmp_op = op; opnd_a = a; opnd_b = b;
    sb.push_back(model(op, a, b, req));
  endtask

  task automatic all_ops(logic [63:0] a, logic [63:0] b, string req);
    for (int k = 0; k < 4; k++) drive(2'(k), a, b, req);
  endtask

  task automatic idle(int n);
    @(negedge clk);
    cmp_valid = 0;
    repeat (n - 1) @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (rst_n && res_valid) begin
      item_t e;
      checks++;
      if (sb.size() == 0) begin
        errors++;
        $display("FAIL R9: unexpected res_valid, actual 1 expected 0");
      end else begin
        e = sb.pop_front();
        if (res_word !== e.word || res_invalid !== e.inv) begin
          errors++;
          $display("FAIL %s: actual word=%h inv=%0b expected word=%h inv=%0b",
                   e.req, res_word, res_invalid, e.word, e.inv);
        end
      end
    end else if (rst_n && res_invalid) begin
      checks++; errors++;
      $display("FAIL R9: res_invalid without res_valid, actual 1 expected 0");
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (res_valid !== 0 || res_invalid !== 0 || res_word !== 0) begin
      errors++;
      $display("FAIL R10: actual v=%0b i=%0b w=%h expected 0 0 0", res_valid, res_invalid, res_word);
    end
    rst_n = 1;
    all_ops(P1, P1, "R5");
    all_ops(P1, P15, "R7");
    all_ops(P2, P15, "R7");
    all_ops(DEN, P1, "R7");
    all_ops(P1, PINF, "R7");
    all_ops(N1, N15, "R8");
    all_ops(N2, N1, "R8");
    all_ops(NINF, N2, "R8");
    all_ops(N1, P1, "R6");
    all_ops(P1, N2, "R6");
    all_ops(N0, DEN, "R6");
    all_ops(P0, N0, "R4");
    all_ops(N0, P0, "R4");
    all_ops(N0, N0, "R4");
    all_ops(QN, P1, "R2");
    all_ops(P1, QN, "R2");
    all_ops(SN, P1, "R3");
    all_ops(P0, SN, "R3");
    all_ops(QN, SN, "R3");
    all_ops(QN, QN, "R2");
    all_ops(P15, N15, "R1");
    idle(3);
    checks++;
    if (res_valid !== 0) begin
      errors++;
      $display("FAIL R9: actual res_valid=%0b expected 0 when idle", res_valid);
    end
    all_ops(SN, SN, "R3");
    idle(3);
    checks++;
    if (sb.size() != 0) begin
      errors++;
      $display("FAIL R9: actual %0d results missing expected 0", sb.size());
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule